// File: doc/BRIEF.md
# Load-Use Hazard Stall Controller

This block watches the decode and execute stages of a five-stage in-order pipeline and holds back an instruction that needs a result a load has not yet produced. A stall starts when the execute stage holds a valid load that writes a register and the decode-stage instruction actually reads that register. For one cycle the program counter and the fetch/decode register then keep their values, and the execute stage receives an empty slot whose write enables are all clear. On the next cycle the load has moved on to the memory stage, where forwarding can supply its value, so the held instruction proceeds. Register zero is never treated as a dependency. An instruction that is two or more stages ahead never causes a stall, because the register file writes in the first half of a cycle and reads in the second.

The block also contains the program counter and the fetch/decode and decode/execute pipeline registers, so the effect of every stall can be seen cycle by cycle at the ports. The fetch side presents one decoded instruction per cycle: its valid bit, its source and destination indices, which sources it reads, and its load, store and register-write flags. A flush request from the branch logic overrides a stall in the same cycle. The PC loads the redirect target, and both the fetched and the decode-stage instructions are squashed.

Top module: `ld_use_stall_unit`

## Requirements
- R1: A stall asserts `pc_hold`, `ifid_hold` and `idex_bubble` together when four things hold: the decode slot is valid, the execute slot is valid with both `ex_mem_rd` and `ex_reg_wr` set, a source the decode instruction reads (`if_use_rs` for rs, `if_use_rt` for rt, as captured at fetch) equals `ex_rd`, and `flush_req` is low.
- R2: A source index of 0 never causes a stall, even when `ex_rd` is 0.
- R3: During a stall, `pc_q` keeps its value into the next cycle. While the unit is held, the fetch inputs have no effect.
- R4: During a stall, `id_valid`, `id_rs`, `id_rt` and `id_pc` keep their values into the next cycle.
- R5: The cycle after `idex_bubble`, `ex_valid`, `ex_mem_rd`, `ex_mem_wr` and `ex_reg_wr` are all 0, and `ex_rd` and `ex_pc` are 0.
- R6: There is no stall when the execute-stage producer is not a load, or when a load that matches a source is one stage further along (memory or writeback).
- R7: A stall never lasts more than one cycle in a row.
- R8: A match on a source the decode instruction does not read causes no stall.
- R9: When `flush_req` is high, `pc_hold` and `ifid_hold` are 0 and `idex_bubble` is 1. On the next cycle `pc_q` equals the `flush_target` that was sampled, and `id_valid` and `ex_valid` are 0.
- R10: While `rst_n` is low at a clock edge, `pc_q` becomes `RESET_PC` (0 by default), all valid bits and write enables clear, and no hold or bubble output is set.
- R11: With no stall and no flush, `pc_q` advances by `PC_STEP` (4). The decode stage loads the fetch inputs, with every control bit ANDed with `if_valid`, together with the old `pc_q`. The execute stage loads the old decode-stage contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| if_valid | input | 1 | Fetched instruction is valid |
| if_rs | input | RIDX_W | First source index of fetched instruction |
| if_rt | input | RIDX_W | Second source index of fetched instruction |
| if_rd | input | RIDX_W | Destination index of fetched instruction |
| if_use_rs | input | 1 | Fetched instruction reads its first source |
| if_use_rt | input | 1 | Fetched instruction reads its second source |
| if_mem_rd | input | 1 | Fetched instruction is a load |
| if_mem_wr | input | 1 | Fetched instruction is a store |
| if_reg_wr | input | 1 | Fetched instruction writes a register |
| flush_req | input | 1 | Redirect request from branch logic |
| flush_target | input | PC_W | Redirect address |
| pc_q | output | PC_W | Current fetch address |
| pc_hold | output | 1 | PC is frozen this cycle |
| ifid_hold | output | 1 | Fetch/decode register is frozen this cycle |
| idex_bubble | output | 1 | Decode/execute register loads an empty slot |
| id_valid | output | 1 | Decode slot is valid |
| id_rs | output | RIDX_W | Decode-stage first source index |
| id_rt | output | RIDX_W | Decode-stage second source index |
| id_pc | output | PC_W | Decode-stage instruction address |
| ex_valid | output | 1 | Execute slot is valid |
| ex_rd | output | RIDX_W | Execute-stage destination index |
| ex_mem_rd | output | 1 | Execute-stage load flag |
| ex_mem_wr | output | 1 | Execute-stage store flag |
| ex_reg_wr | output | 1 | Execute-stage register-write flag |
| ex_pc | output | PC_W | Execute-stage instruction address |

## Verification
A missed stall shows one cycle later: `pc_q` advances and the dependent instruction appears in `ex_pc` directly behind the load, with no empty slot between them. A false stall shows in the same cycle as a raised `pc_hold`, and on the next edge as a repeated `pc_q` together with an invalid execute slot. A bubble that leaks a write enable, or a flush that loses to a stall, is visible on the execute-stage flags or on `pc_q` one clock edge after the cause. The random stream draws register indices from a small range, so matches, zero indices and unread operands come up often. The stream is compared every cycle against a cycle model of the requirements.

// File: rtl/lus_pkg.sv
// Package: shared control-word types for the load-use stall unit.
// Assumes: control words carry only enables; indices and addresses
// are kept beside them with widths set by the top's parameters.
package lus_pkg;

    // Control bits held in the fetch/decode register.
    typedef struct packed {
        logic valid;
        logic use_rs;
        logic use_rt;
        logic mem_rd;
        logic mem_wr;
        logic reg_wr;
    } id_ctrl_t;

    // Control bits held in the decode/execute register.
    typedef struct packed {
        logic valid;
        logic mem_rd;
        logic mem_wr;
        logic reg_wr;
    } ex_ctrl_t;

    // Number of source operands compared per decode instruction.
    localparam int NUM_SRC = 2;

endpackage

// File: rtl/lus_hazard_detect.sv
// Module: lus_hazard_detect
// Purely combinational load-use detector. It compares every source the
// decode instruction reads against the destination of a load in execute,
// skips index zero, and lets a flush request override the hold outputs.
// Assumes: slot 0 of id_src is rs and slot 1 is rt.
module lus_hazard_detect
    import lus_pkg::*;
#(
    parameter int RIDX_W = 5
) (
    input  logic                            id_valid,
    input  logic [NUM_SRC-1:0]              id_use,
    input  logic [NUM_SRC-1:0][RIDX_W-1:0]  id_src,
    input  logic                            ex_valid,
    input  logic                            ex_mem_rd,
    input  logic                            ex_reg_wr,
    input  logic [RIDX_W-1:0]               ex_rd,
    input  logic                            flush_req,
    output logic                            load_use,
    output logic                            pc_hold,
    output logic                            ifid_hold,
    output logic                            idex_bubble
);

    logic               ex_is_load;
    logic [NUM_SRC-1:0] src_hit;

    // A producer can only cause a stall if it is a valid register-writing load.
    assign ex_is_load = ex_valid && ex_mem_rd && ex_reg_wr;

    // One comparator per source operand.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign src_hit[g] = id_valid && id_use[g] && (id_src[g] != '0)
                            && (id_src[g] == ex_rd) && ex_is_load;
    end

    // Combine the comparisons and apply flush priority.
    always_comb begin
        load_use    = |src_hit;
        pc_hold     = load_use && !flush_req;
        ifid_hold   = load_use && !flush_req;
        idex_bubble = load_use || flush_req;
    end

endmodule

// File: rtl/lus_pc_reg.sv
// Module: lus_pc_reg
// Fetch address register. A redirect has priority over a hold, and a hold
// has priority over the sequential step.
// Assumes: synchronous active-low reset to RESET_PC.
module lus_pc_reg #(
    parameter int              PC_W     = 32,
    parameter logic [PC_W-1:0] RESET_PC = '0,
    parameter int              PC_STEP  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold,
    input  logic            redirect,
    input  logic [PC_W-1:0] target,
    output logic [PC_W-1:0] pc_q
);

    localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

    // Select the next fetch address.
    always_ff @(posedge clk) begin
        if (!rst_n)        pc_q <= RESET_PC;
        else if (redirect) pc_q <= target;
        else if (!hold)    pc_q <= pc_q + STEP;
    end

endmodule

// File: rtl/lus_stage_reg.sv
// Module: lus_stage_reg
// Generic pipeline register with clear and hold. Clear (reset or squash)
// zeroes the whole word, so every valid bit and enable in it drops to 0.
// Assumes: clear has priority over hold.
module lus_stage_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         hold,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Load, keep or empty the stage.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) q <= '0;
        else if (!hold)      q <= d;
    end

endmodule

// File: rtl/ld_use_stall_unit.sv
// Module: ld_use_stall_unit
// Top of the load-use stall controller. It holds the PC and the
// fetch/decode and decode/execute registers and uses lus_hazard_detect
// to freeze the front end for one cycle while the execute stage takes
// an empty slot. A flush squashes the fetch and decode stages and
// redirects the PC.
// Assumes: fetch inputs describe the instruction at pc_q, and the
// memory stage forwards a load result to the execute stage.
module ld_use_stall_unit
    import lus_pkg::*;
#(
    parameter int              PC_W     = 32,
    parameter int              RIDX_W   = 5,
    parameter logic [PC_W-1:0] RESET_PC = '0,
    parameter int              PC_STEP  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              if_valid,
    input  logic [RIDX_W-1:0] if_rs,
    input  logic [RIDX_W-1:0] if_rt,
    input  logic [RIDX_W-1:0] if_rd,
    input  logic              if_use_rs,
    input  logic              if_use_rt,
    input  logic              if_mem_rd,
    input  logic              if_mem_wr,
    input  logic              if_reg_wr,
    input  logic              flush_req,
    input  logic [PC_W-1:0]   flush_target,
    output logic [PC_W-1:0]   pc_q,
    output logic              pc_hold,
    output logic              ifid_hold,
    output logic              idex_bubble,
    output logic              id_valid,
    output logic [RIDX_W-1:0] id_rs,
    output logic [RIDX_W-1:0] id_rt,
    output logic [PC_W-1:0]   id_pc,
    output logic              ex_valid,
    output logic [RIDX_W-1:0] ex_rd,
    output logic              ex_mem_rd,
    output logic              ex_mem_wr,
    output logic              ex_reg_wr,
    output logic [PC_W-1:0]   ex_pc
);

    localparam int IDC_W  = $bits(id_ctrl_t);
    localparam int EXC_W  = $bits(ex_ctrl_t);
    localparam int IFID_W = IDC_W + 3 * RIDX_W + PC_W;
    localparam int IDEX_W = EXC_W + RIDX_W + PC_W;

    id_ctrl_t          if_ctrl;
    id_ctrl_t          id_ctrl;
    ex_ctrl_t          id2ex_ctrl;
    ex_ctrl_t          ex_ctrl;
    logic [RIDX_W-1:0] id_rd;
    logic [IFID_W-1:0] ifid_d;
    logic [IFID_W-1:0] ifid_q;
    logic [IDEX_W-1:0] idex_d;
    logic [IDEX_W-1:0] idex_q;
    logic              load_use;

    // Mask every fetched enable with the fetch valid bit.
    always_comb begin
        if_ctrl.valid  = if_valid;
        if_ctrl.use_rs = if_valid && if_use_rs;
        if_ctrl.use_rt = if_valid && if_use_rt;
        if_ctrl.mem_rd = if_valid && if_mem_rd;
        if_ctrl.mem_wr = if_valid && if_mem_wr;
        if_ctrl.reg_wr = if_valid && if_reg_wr;
    end

    assign ifid_d = {if_ctrl, if_rs, if_rt, if_rd, pc_q};

    // Fetch address.
    lus_pc_reg #(
        .PC_W     (PC_W),
        .RESET_PC (RESET_PC),
        .PC_STEP  (PC_STEP)
    ) u_pc (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (pc_hold),
        .redirect (flush_req),
        .target   (flush_target),
        .pc_q     (pc_q)
    );

    // Fetch/decode register: squashed by a flush, frozen by a stall.
    lus_stage_reg #(.W(IFID_W)) u_ifid (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (flush_req),
        .hold  (ifid_hold),
        .d     (ifid_d),
        .q     (ifid_q)
    );

    assign {id_ctrl, id_rs, id_rt, id_rd, id_pc} = ifid_q;
    assign id_valid = id_ctrl.valid;

    // Load-use comparison against the execute stage.
    lus_hazard_detect #(.RIDX_W(RIDX_W)) u_detect (
        .id_valid    (id_ctrl.valid),
        .id_use      ({id_ctrl.use_rt, id_ctrl.use_rs}),
        .id_src      ({id_rt, id_rs}),
        .ex_valid    (ex_ctrl.valid),
        .ex_mem_rd   (ex_ctrl.mem_rd),
        .ex_reg_wr   (ex_ctrl.reg_wr),
        .ex_rd       (ex_rd),
        .flush_req   (flush_req),
        .load_use    (load_use),
        .pc_hold     (pc_hold),
        .ifid_hold   (ifid_hold),
        .idex_bubble (idex_bubble)
    );

    // Reduce the decode control word to what the execute stage carries.
    always_comb begin
        id2ex_ctrl.valid  = id_ctrl.valid;
        id2ex_ctrl.mem_rd = id_ctrl.mem_rd;
        id2ex_ctrl.mem_wr = id_ctrl.mem_wr;
        id2ex_ctrl.reg_wr = id_ctrl.reg_wr;
    end

    assign idex_d = {id2ex_ctrl, id_rd, id_pc};

    // Decode/execute register: never held, emptied on a bubble.
    lus_stage_reg #(.W(IDEX_W)) u_idex (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (idex_bubble),
        .hold  (1'b0),
        .d     (idex_d),
        .q     (idex_q)
    );

    assign {ex_ctrl, ex_rd, ex_pc} = idex_q;
    assign ex_valid  = ex_ctrl.valid;
    assign ex_mem_rd = ex_ctrl.mem_rd;
    assign ex_mem_wr = ex_ctrl.mem_wr;
    assign ex_reg_wr = ex_ctrl.reg_wr;

endmodule

// File: rtl/lus_stall_checker.sv
// Module: lus_stall_checker
// Timing properties of the stall unit, bound to ld_use_stall_unit.
// Assumes: the synchronous active-low reset disables every property.
module lus_stall_checker #(
    parameter int PC_W    = 32,
    parameter int RIDX_W  = 5,
    parameter int PC_STEP = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush_req,
    input logic [PC_W-1:0]   flush_target,
    input logic [PC_W-1:0]   pc_q,
    input logic              pc_hold,
    input logic              ifid_hold,
    input logic              idex_bubble,
    input logic              id_valid,
    input logic              id_use_rs,
    input logic              id_use_rt,
    input logic [RIDX_W-1:0] id_rs,
    input logic [RIDX_W-1:0] id_rt,
    input logic [PC_W-1:0]   id_pc,
    input logic              ex_valid,
    input logic [RIDX_W-1:0] ex_rd,
    input logic              ex_mem_rd,
    input logic              ex_mem_wr,
    input logic              ex_reg_wr
);

    p_stall_triple_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hold |-> (ifid_hold && idex_bubble));

    p_zero_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hold |-> (ex_rd != '0));

    p_pc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hold |=> $stable(pc_q));

    p_ifid_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ifid_hold |=> ($stable(id_valid) && $stable(id_rs) && $stable(id_rt) && $stable(id_pc)));

    p_bubble_r5: assert property (@(posedge clk) disable iff (!rst_n)
        idex_bubble |=> (!ex_valid && !ex_mem_rd && !ex_mem_wr && !ex_reg_wr));

    p_load_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hold |-> (ex_valid && ex_mem_rd && ex_reg_wr));

    p_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hold |=> !pc_hold);

    p_unused_rt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_hold && !(id_use_rs && id_rs == ex_rd)) |-> id_use_rt);

    p_flush_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> (!pc_hold && !ifid_hold && idex_bubble));

    p_flush_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |=> (pc_q == $past(flush_target) && !id_valid && !ex_valid));

    p_advance_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_hold && !flush_req) |=> (pc_q == $past(pc_q) + PC_W'(PC_STEP)));

endmodule

bind ld_use_stall_unit lus_stall_checker #(
    .PC_W    (PC_W),
    .RIDX_W  (RIDX_W),
    .PC_STEP (PC_STEP)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush_req    (flush_req),
    .flush_target (flush_target),
    .pc_q         (pc_q),
    .pc_hold      (pc_hold),
    .ifid_hold    (ifid_hold),
    .idex_bubble  (idex_bubble),
    .id_valid     (id_valid),
    .id_use_rs    (id_ctrl.use_rs),
    .id_use_rt    (id_ctrl.use_rt),
    .id_rs        (id_rs),
    .id_rt        (id_rt),
    .id_pc        (id_pc),
    .ex_valid     (ex_valid),
    .ex_rd        (ex_rd),
    .ex_mem_rd    (ex_mem_rd),
    .ex_mem_wr    (ex_mem_wr),
    .ex_reg_wr    (ex_reg_wr)
);

// File: tb/ld_use_stall_unit_bench.sv
// Bench for ld_use_stall_unit: directed corner cases, then a seeded random
// stream, each compared against a cycle model written from the requirements.
module ld_use_stall_unit_bench;

    localparam int PC_W   = 32;
    localparam int RIDX_W = 5;
    localparam int NRAND  = 4000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              if_valid = 1'b0;
    logic [RIDX_W-1:0] if_rs = '0, if_rt = '0, if_rd = '0;
    logic              if_use_rs = 1'b0, if_use_rt = 1'b0;
    logic              if_mem_rd = 1'b0, if_mem_wr = 1'b0, if_reg_wr = 1'b0;
    logic              flush_req = 1'b0;
    logic [PC_W-1:0]   flush_target = '0;
    logic [PC_W-1:0]   pc_q, id_pc, ex_pc;
    logic              pc_hold, ifid_hold, idex_bubble;
    logic              id_valid, ex_valid, ex_mem_rd, ex_mem_wr, ex_reg_wr;
    logic [RIDX_W-1:0] id_rs, id_rt, ex_rd;

    int n_chk = 0;
    int n_fail = 0;

    // Cycle model state.
    logic [PC_W-1:0]   m_pc, m_id_pc, m_ex_pc;
    logic              m_id_v, m_id_urs, m_id_urt, m_id_mr, m_id_mw, m_id_rw;
    logic [RIDX_W-1:0] m_id_rs, m_id_rt, m_id_rd, m_ex_rd;
    logic              m_ex_v, m_ex_mr, m_ex_mw, m_ex_rw;
    logic              prev_hold;

    always #5 clk = ~clk;

    ld_use_stall_unit u_ld_use_stall_unit (
        .clk(clk), .rst_n(rst_n), .if_valid(if_valid), .if_rs(if_rs),
        .if_rt(if_rt), .if_rd(if_rd), .if_use_rs(if_use_rs),
        .if_use_rt(if_use_rt), .if_mem_rd(if_mem_rd), .if_mem_wr(if_mem_wr),
        .if_reg_wr(if_reg_wr), .flush_req(flush_req),
        .flush_target(flush_target), .pc_q(pc_q), .pc_hold(pc_hold),
        .ifid_hold(ifid_hold), .idex_bubble(idex_bubble), .id_valid(id_valid),
        .id_rs(id_rs), .id_rt(id_rt), .id_pc(id_pc), .ex_valid(ex_valid),
        .ex_rd(ex_rd), .ex_mem_rd(ex_mem_rd), .ex_mem_wr(ex_mem_wr),
        .ex_reg_wr(ex_reg_wr), .ex_pc(ex_pc)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_pc = '0; m_id_pc = '0; m_ex_pc = '0;
        {m_id_v, m_id_urs, m_id_urt, m_id_mr, m_id_mw, m_id_rw} = '0;
        m_id_rs = '0; m_id_rt = '0; m_id_rd = '0; m_ex_rd = '0;
        {m_ex_v, m_ex_mr, m_ex_mw, m_ex_rw} = '0;
        prev_hold = 1'b0;
    endtask

    // Expected hazard from the model: a valid register-writing load in execute
    // whose destination equals a non-zero source that decode reads.
    function automatic logic f_hazard();
        logic ld = m_ex_v && m_ex_mr && m_ex_rw;
        logic h0 = m_id_v && m_id_urs && m_id_rs != '0 && m_id_rs == m_ex_rd && ld;
        logic h1 = m_id_v && m_id_urt && m_id_rt != '0 && m_id_rt == m_ex_rd && ld;
        return h0 || h1;
    endfunction

    // One clock: check combinational outputs, advance the model, check registers.
    task automatic step();
        logic hz, ehold, ebub, ld;
        string ctag, ptag, itag, etag;
        #1;
        hz    = f_hazard();
        ld    = m_ex_v && m_ex_mr && m_ex_rw;
        ehold = hz && !flush_req;
        ebub  = hz || flush_req;
        if (flush_req) ctag = "R9";
        else if (hz) ctag = "R1";
        else if (ld && m_id_v && m_ex_rd == '0 &&
                 ((m_id_urs && m_id_rs == '0) || (m_id_urt && m_id_rt == '0))) ctag = "R2";
        else if (ld && m_id_v && !m_id_urt && m_id_rt == m_ex_rd) ctag = "R8";
        else if (prev_hold) ctag = "R7";
        else ctag = "R6";
        check(ctag, {61'd0, pc_hold, ifid_hold, idex_bubble}, {61'd0, ehold, ehold, ebub});

        ptag = flush_req ? "R9" : (hz ? "R3" : "R11");
        itag = flush_req ? "R9" : (hz ? "R4" : "R11");
        etag = ebub ? "R5" : "R11";
        if (flush_req) begin
            m_pc = flush_target;
            {m_id_v, m_id_urs, m_id_urt, m_id_mr, m_id_mw, m_id_rw} = '0;
            m_id_rs = '0; m_id_rt = '0; m_id_rd = '0; m_id_pc = '0;
            {m_ex_v, m_ex_mr, m_ex_mw, m_ex_rw} = '0; m_ex_rd = '0; m_ex_pc = '0;
        end else if (hz) begin
            {m_ex_v, m_ex_mr, m_ex_mw, m_ex_rw} = '0; m_ex_rd = '0; m_ex_pc = '0;
        end else begin
            m_ex_v = m_id_v; m_ex_mr = m_id_mr; m_ex_mw = m_id_mw; m_ex_rw = m_id_rw;
            m_ex_rd = m_id_rd; m_ex_pc = m_id_pc;
            m_id_v = if_valid; m_id_urs = if_valid && if_use_rs; m_id_urt = if_valid && if_use_rt;
            m_id_mr = if_valid && if_mem_rd; m_id_mw = if_valid && if_mem_wr;
            m_id_rw = if_valid && if_reg_wr;
            m_id_rs = if_rs; m_id_rt = if_rt; m_id_rd = if_rd; m_id_pc = m_pc;
            m_pc = m_pc + 32'd4;
        end
        prev_hold = ehold;

        @(posedge clk);
        @(negedge clk);
        check(ptag, {32'd0, pc_q}, {32'd0, m_pc});
        check(itag, {21'd0, id_valid, id_rs, id_rt, id_pc}, {21'd0, m_id_v, m_id_rs, m_id_rt, m_id_pc});
        check(etag, {23'd0, ex_valid, ex_rd, ex_mem_rd, ex_mem_wr, ex_reg_wr, ex_pc},
                    {23'd0, m_ex_v, m_ex_rd, m_ex_mr, m_ex_mw, m_ex_rw, m_ex_pc});
    endtask

    task automatic put(input logic v, input int rs, input int rt, input int rd,
                       input logic urs, input logic urt, input logic mr,
                       input logic mw, input logic rw, input logic fl);
        if_valid = v; if_rs = RIDX_W'(rs); if_rt = RIDX_W'(rt); if_rd = RIDX_W'(rd);
        if_use_rs = urs; if_use_rt = urt; if_mem_rd = mr; if_mem_wr = mw;
        if_reg_wr = rw; flush_req = fl; flush_target = 32'h0000_4000;
        step();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        #2000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired at %0t", $time);
        summary();
    end

    initial begin
        void'($urandom(32'h1f2e3d4c));
        model_reset();
        repeat (3) @(negedge clk);
        // R10: reset state at the ports.
        check("R10", {21'd0, pc_q, pc_hold, ifid_hold, idex_bubble, id_valid, ex_valid,
                      ex_mem_rd, ex_mem_wr, ex_reg_wr, ex_rd},
                     64'd0);
        rst_n = 1'b1;

        // R1/R7: load r3 then a reader of r3.
        put(1, 1, 0, 3, 1, 0, 1, 0, 1, 0);
        put(1, 3, 2, 4, 1, 1, 0, 0, 1, 0);
        put(1, 5, 6, 7, 1, 1, 0, 0, 1, 0);
        put(1, 5, 6, 7, 1, 1, 0, 0, 1, 0);
        // R2: load into r0, reader of r0.
        put(1, 1, 0, 0, 1, 0, 1, 0, 1, 0);
        put(1, 0, 0, 4, 1, 1, 0, 0, 1, 0);
        // R8: load r5, instruction with unread rt equal to 5.
        put(1, 1, 0, 5, 1, 0, 1, 0, 1, 0);
        put(1, 2, 5, 4, 1, 0, 0, 0, 1, 0);
        // R6: load r6, filler, reader of r6 (load is in memory stage).
        put(1, 1, 0, 6, 1, 0, 1, 0, 1, 0);
        put(1, 2, 2, 8, 1, 1, 0, 0, 1, 0);
        put(1, 6, 6, 9, 1, 1, 0, 0, 1, 0);
        // R6: non-load producer followed by a reader.
        put(1, 1, 1, 10, 1, 1, 0, 0, 1, 0);
        put(1, 10, 10, 11, 1, 1, 0, 0, 1, 0);
        // R9: stall and flush in the same cycle.
        put(1, 1, 0, 7, 1, 0, 1, 0, 1, 0);
        put(1, 7, 7, 12, 1, 1, 0, 0, 1, 0);
        put(1, 7, 7, 12, 1, 1, 0, 0, 1, 1);
        put(1, 2, 3, 4, 1, 1, 0, 0, 1, 0);

        // Random stream with small index range so matches are frequent.
        for (int i = 0; i < NRAND; i++) begin
            if_valid     = ($urandom % 8) != 0;
            if_rs        = RIDX_W'($urandom % 4);
            if_rt        = RIDX_W'($urandom % 4);
            if_rd        = RIDX_W'($urandom % 4);
            if_use_rs    = ($urandom % 4) != 0;
            if_use_rt    = ($urandom % 2) != 0;
            if_mem_rd    = ($urandom % 5) < 2;
            if_mem_wr    = ($urandom % 6) == 0;
            if_reg_wr    = ($urandom % 4) != 0;
            flush_req    = ($urandom % 16) == 0;
            flush_target = {$urandom, 2'b00};
            if ((i % 500) == 250) begin
                rst_n = 1'b0;
                step_reset();
                rst_n = 1'b1;
            end else begin
                step();
            end
        end
        summary();
    end

    // Reset inside the random stream: R10 after one synchronous reset edge.
    task automatic step_reset();
        @(posedge clk);
        @(negedge clk);
        model_reset();
        check("R10", {21'd0, pc_q, pc_hold, ifid_hold, idex_bubble, id_valid, ex_valid,
                      ex_mem_rd, ex_mem_wr, ex_reg_wr, ex_rd},
                     {21'd0, 32'd0, 1'b0, 1'b0, flush_req, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0});
    endtask

endmodule